// File: doc/BRIEF.md
# Expansion Card Autoconfiguration Responder

After reset this block makes an expansion card answer in a fixed 64K configuration window. There the card shows a read-only table of configuration nibbles. The table gives the board type, the vendor, the product, the serial number and the boot ROM vector. Host enumeration software reads the table. It then writes a base page in two steps: a low nibble first, then a commit of the high nibble. On the commit the card's 64K decode window moves to that page, and the configuration window goes quiet. The host can instead send a shut-up command, which silences the card until the next reset.

The bus side is nibble wide. The data ports are the upper four data lines of a byte access. The byte address is sampled on each clock edge while a read or write strobe is high. The results are registered and appear one cycle later: a card-select flag, the read nibble, and a flag that shows the card has been relocated. The card's local registers sit behind the same window, and the select output covers them. This block does not decode them.

Top module: `autocfg_responder`

## Requirements
- R1: After reset, sel_o is 0, rdata_o is 4'hF and configured_o is 0, and the card decodes the configuration page 8'hE8 (addresses 24'hE8xxxx).
- R2: A read at an even local offset below 8'h80 returns a configuration nibble on rdata_o, one cycle after the strobe. The port rdata_o carries data bits 7:4. Byte k of the table sits at offset 4k: its high nibble is at 4k and its low nibble at 4k+2. Odd offsets, other local offsets, writes and idle cycles return 4'hF.
- R3: The nibbles at offsets 8'h00 and 8'h02 are returned as they are. Every other nibble is returned inverted. Table byte 0 is 8'hD1. Its fields are: bits 7:6 = 11 for the bus type, bit 5 = 0 so the board is not added to free memory, bit 4 = 1 for a valid ROM vector, bit 3 = 0 for no chained board, and bits 2:0 = 001 for a 64K size.
- R4: The table bytes are as follows. The product is 8'h00 at byte 1. The flags are 8'h00 at byte 2, meaning no space preference and shut-up accepted. The vendor is 16'h1212 at bytes 4 and 5. The serial number is 32'h0 at bytes 6 to 9. The ROM vector is 16'h1000 at bytes 10 and 11. All other bytes are 0.
- R5: A write at offset 8'h4A, made while the card is unconfigured, latches wdata_i as the low nibble of the base. Repeated writes there overwrite the nibble, and the last one wins. None of them moves the card.
- R6: A write at offset 8'h48, made while the card is unconfigured, commits the base {wdata_i, latched low nibble}. That write is itself selected. configured_o reads 1 in the same sampling cycle as that write's select.
- R7: After the commit, accesses in page 8'hE8 are not selected, unless the base is 8'hE8. Accesses in the new base page are selected, and the configuration nibbles appear there at offsets below 8'h80.
- R8: A commit with no earlier write at 8'h4A since reset uses the reset value 0 as the low nibble.
- R9: Before configuration, the local registers in the configuration window are selected, for example at offsets 16'h07FE and 16'h0800.
- R10: A write at offset 8'h4C, made while the card is unconfigured, is selected. From the next access on, no address is selected and configured_o stays 0, even when a commit write follows. This lasts until reset.
- R11: Reset clears the configured and shut-up states and returns the card to page 8'hE8.
- R12: After configuration, writes at offsets 8'h48, 8'h4A and 8'h4C have no effect. The card stays at its base.
- R13: An access outside the current window is not selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 24 | Bus byte address |
| wdata_i | input | 4 | Write data, upper nibble of the data byte |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 4 | Registered read nibble |
| sel_o | output | 1 | Registered card select |
| configured_o | output | 1 | Card has been relocated |

## Verification
The commit write does two things in one cycle. It is answered by the old configuration window, and at the same clock edge it moves the window. The shut-up write behaves the same way: it is selected as it silences the card. The bench issues each of these writes and expects select on it. On the very next cycle it accesses the old page and the new page. It judges the edge from the select and the configured flag sampled on each of those cycles.

// File: rtl/autocfg_pkg.sv
package autocfg_pkg;
  localparam int unsigned WIN_BITS = 16;
  localparam int unsigned CFG_LIMIT_BITS = 7;
  localparam logic [6:0] OFF_COMMIT = 7'h48;
  localparam logic [6:0] OFF_LOW    = 7'h4A;
  localparam logic [6:0] OFF_SILENT = 7'h4C;

  function automatic logic [7:0] type_byte(input logic [2:0] size_code,
                                           input logic on_freelist,
                                           input logic vector_ok,
                                           input logic chained);
    return {2'b11, on_freelist, vector_ok, chained, size_code};
  endfunction
endpackage

// File: rtl/autocfg_nibble_rom.sv
module autocfg_nibble_rom #(
  parameter logic [7:0]  TYPE_B   = 8'hD1,
  parameter logic [7:0]  PRODUCT  = 8'h00,
  parameter logic [7:0]  FLAGS_B  = 8'h00,
  parameter logic [15:0] VENDOR   = 16'h1212,
  parameter logic [31:0] SERIAL   = 32'h0,
  parameter logic [15:0] ROMVEC   = 16'h1000
) (
  input  logic [5:0] slot_i,
  output logic [3:0] nib_o
);
  logic [4:0] idx;
  logic [7:0] cur;
  logic [3:0] raw;

  assign idx = slot_i[5:1];

  always_comb begin
    case (idx)
      5'd0:  cur = TYPE_B;
      5'd1:  cur = PRODUCT;
      5'd2:  cur = FLAGS_B;
      5'd4:  cur = VENDOR[15:8];
      5'd5:  cur = VENDOR[7:0];
      5'd6:  cur = SERIAL[31:24];
      5'd7:  cur = SERIAL[23:16];
      5'd8:  cur = SERIAL[15:8];
      5'd9:  cur = SERIAL[7:0];
      5'd10: cur = ROMVEC[15:8];
      5'd11: cur = ROMVEC[7:0];
      default: cur = 8'h00;
    endcase
  end

  assign raw   = slot_i[0] ? cur[3:0] : cur[7:4];
  assign nib_o = (slot_i < 6'd2) ? raw : ~raw;
endmodule

// File: rtl/autocfg_win_decode.sv
module autocfg_win_decode #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned CFG_PAGE = 'hE8,
  localparam int unsigned PAGE_W  = ADDR_W - autocfg_pkg::WIN_BITS
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] base_i,
  input  logic              configured_i,
  input  logic              silent_i,
  output logic              hit_o,
  output logic              cfg_space_o,
  output logic [autocfg_pkg::WIN_BITS-1:0] off_o
);
  import autocfg_pkg::*;
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] want;

  assign page  = addr_i[ADDR_W-1:WIN_BITS];
  assign off_o = addr_i[WIN_BITS-1:0];
  assign want  = configured_i ? base_i : PAGE_W'(CFG_PAGE);
  assign hit_o = !silent_i && (page == want);
  assign cfg_space_o = (off_o[WIN_BITS-1:CFG_LIMIT_BITS] == '0);
endmodule

// File: rtl/autocfg_state.sv
module autocfg_state #(
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned HI_W  = PAGE_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_cfg_i,
  input  logic [6:0]        off_i,
  input  logic [3:0]        wnib_i,
  output logic [PAGE_W-1:0] base_o,
  output logic              configured_o,
  output logic              silent_o
);
  import autocfg_pkg::*;
  logic [3:0] low_q;
  logic       do_low, do_commit, do_silent;

  assign do_low    = wr_cfg_i && (off_i == OFF_LOW)    && !configured_o && !silent_o;
  assign do_commit = wr_cfg_i && (off_i == OFF_COMMIT) && !configured_o && !silent_o;
  assign do_silent = wr_cfg_i && (off_i == OFF_SILENT) && !configured_o && !silent_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      low_q        <= 4'h0;
      base_o       <= '0;
      configured_o <= 1'b0;
      silent_o     <= 1'b0;
    end else begin
      if (do_low)    low_q <= wnib_i;
      if (do_commit) begin
        base_o       <= {HI_W'(wnib_i), low_q};
        configured_o <= 1'b1;
      end
      if (do_silent) silent_o <= 1'b1;
    end
  end

  // R6
  configured_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    configured_o |=> configured_o);
  // R10
  silent_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    silent_o |=> (silent_o && !configured_o));
  // R6
  commit_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_cfg_i && off_i == 7'h48 && !configured_o && !silent_o)
      |=> (configured_o && base_o[3:0] == $past(low_q)));
  // R12
  base_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    configured_o |=> $stable(base_o));
endmodule

// File: rtl/autocfg_responder.sv
module autocfg_responder #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned CFG_PAGE = 'hE8,
  parameter logic [15:0] VENDOR   = 16'h1212,
  parameter logic [7:0]  PRODUCT  = 8'h00,
  parameter logic [31:0] SERIAL   = 32'h0,
  parameter logic [15:0] ROMVEC   = 16'h1000,
  parameter logic [2:0]  SIZE_CODE = 3'b001,
  localparam int unsigned PAGE_W  = ADDR_W - autocfg_pkg::WIN_BITS
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [3:0]        rdata_o,
  output logic              sel_o,
  output logic              configured_o
);
  import autocfg_pkg::*;
  localparam logic [7:0] TYPE_B = type_byte(SIZE_CODE, 1'b0, 1'b1, 1'b0);

  logic [PAGE_W-1:0]   base;
  logic                silent, hit, cfg_space;
  logic [WIN_BITS-1:0] off;
  logic [3:0]          nib;

  autocfg_win_decode #(.ADDR_W(ADDR_W), .CFG_PAGE(CFG_PAGE)) u_dec (
    .addr_i(addr_i), .base_i(base), .configured_i(configured_o),
    .silent_i(silent), .hit_o(hit), .cfg_space_o(cfg_space), .off_o(off)
  );

  autocfg_state #(.PAGE_W(PAGE_W)) u_state (
    .clk_i(clk_i), .rst_i(rst_i), .wr_cfg_i(wr_i && hit && cfg_space),
    .off_i(off[6:0]), .wnib_i(wdata_i), .base_o(base),
    .configured_o(configured_o), .silent_o(silent)
  );

  autocfg_nibble_rom #(
    .TYPE_B(TYPE_B), .PRODUCT(PRODUCT), .FLAGS_B(8'h00),
    .VENDOR(VENDOR), .SERIAL(SERIAL), .ROMVEC(ROMVEC)
  ) u_rom (.slot_i(off[6:1]), .nib_o(nib));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_o   <= 1'b0;
      rdata_o <= 4'hF;
    end else begin
      sel_o   <= (rd_i || wr_i) && hit;
      rdata_o <= (rd_i && hit && cfg_space && !off[0]) ? nib : 4'hF;
    end
  end

  // R10
  silent_no_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    silent |=> !sel_o);
  // R2
  data_needs_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rdata_o != 4'hF) |-> sel_o);
  // R7
  old_window_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (configured_o && (rd_i || wr_i) && addr_i[ADDR_W-1:WIN_BITS] == PAGE_W'(CFG_PAGE)
      && base != PAGE_W'(CFG_PAGE)) |=> !sel_o);
endmodule

// File: tb/autocfg_responder_test.sv
module autocfg_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [3:0]  rdata;
  logic        sel, configured;

  typedef struct {
    logic       sel;
    logic [3:0] nib;
    logic       cfg;
    string      tag;
  } exp_t;
  exp_t q[$];

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  autocfg_responder uut (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .sel_o(sel), .configured_o(configured)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // table bytes as given in R3 and R4
  function automatic logic [7:0] tbl(input int k);
    case (k)
      0: return 8'hD1;
      4: return 8'h12;
      5: return 8'h12;
      10: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] cfg_nib(input logic [6:0] off);
    logic [7:0] b;
    logic [3:0] n;
    b = tbl(int'(off[6:2]));
    n = off[1] ? b[3:0] : b[7:4];
    return (off == 7'h00 || off == 7'h02) ? n : ~n;
  endfunction

  task automatic acc(input logic r, input logic w, input logic [23:0] a,
                     input logic [3:0] d, input logic es, input logic [3:0] en,
                     input logic ec, input string tag);
    exp_t e;
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d;
    e.sel = es; e.nib = en; e.cfg = ec; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rd_cfg(input logic [23:0] a, input logic ec, input string tag);
    acc(1, 0, a, 4'h0, 1'b1, cfg_nib(a[6:0]), ec, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rd = 0; wr = 0; rst = 1;
    @(negedge clk);
    rst = 0;
  endtask

  // monitor: pops one expectation per cycle, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (sel !== e.sel || rdata !== e.nib || configured !== e.cfg) begin
        fails++;
        $display("FAIL %s: sel/rdata/configured actual %b/%h/%b expected %b/%h/%b",
                 e.tag, sel, rdata, configured, e.sel, e.nib, e.cfg);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    acc(0, 0, 24'h0, 4'h0, 0, 4'hF, 0, "R1 reset idle");
    // R3: first two nibbles raw, type byte 8'hD1
    rd_cfg(24'hE80000, 0, "R3 type hi");
    rd_cfg(24'hE80002, 0, "R3 type lo");
    rd_cfg(24'hE80004, 0, "R4 product");
    rd_cfg(24'hE80008, 0, "R4 flags");
    rd_cfg(24'hE80010, 0, "R4 vendor b4 hi");
    rd_cfg(24'hE80012, 0, "R4 vendor b4 lo");
    rd_cfg(24'hE80014, 0, "R4 vendor b5 hi");
    rd_cfg(24'hE80016, 0, "R4 vendor b5 lo");
    rd_cfg(24'hE8001A, 0, "R4 serial");
    rd_cfg(24'hE80028, 0, "R4 romvec hi");
    rd_cfg(24'hE8002A, 0, "R4 romvec lo2");
    rd_cfg(24'hE8002C, 0, "R4 romvec b11");
    acc(1, 0, 24'hE80001, 4'h0, 1, 4'hF, 0, "R2 odd offset");
    acc(1, 0, 24'hE807FE, 4'h0, 1, 4'hF, 0, "R9 local reg read");
    acc(0, 1, 24'hE80800, 4'h3, 1, 4'hF, 0, "R9 local reg write");
    acc(1, 0, 24'hE90000, 4'h0, 0, 4'hF, 0, "R13 outside window");
    // R5: low nibble, last write wins
    acc(0, 1, 24'hE8004A, 4'h3, 1, 4'hF, 0, "R5 low write 1");
    acc(0, 1, 24'hE8004A, 4'h5, 1, 4'hF, 0, "R5 low write 2");
    rd_cfg(24'hE80000, 0, "R5 still in cfg window");
    // R6: commit, selected on the commit write itself
    acc(0, 1, 24'hE80048, 4'h2, 1, 4'hF, 1, "R6 commit");
    acc(1, 0, 24'hE80000, 4'h0, 0, 4'hF, 1, "R7 old window quiet");
    rd_cfg(24'h250000, 1, "R7 new base nibble");
    rd_cfg(24'h250010, 1, "R7 new base vendor");
    acc(1, 0, 24'h250800, 4'h0, 1, 4'hF, 1, "R7 new base local");
    acc(1, 0, 24'h230000, 4'h0, 0, 4'hF, 1, "R13 wrong page");
    // R12: config writes ignored once placed
    acc(0, 1, 24'h25004A, 4'h9, 1, 4'hF, 1, "R12 low write ignored");
    acc(0, 1, 24'h250048, 4'h7, 1, 4'hF, 1, "R12 commit ignored");
    acc(0, 1, 24'h25004C, 4'h0, 1, 4'hF, 1, "R12 silent ignored");
    rd_cfg(24'h250002, 1, "R12 base kept");
    acc(1, 0, 24'h790000, 4'h0, 0, 4'hF, 1, "R12 no move");
    // R11: reset returns the card to the configuration window
    do_reset();
    acc(0, 0, 24'h0, 4'h0, 0, 4'hF, 0, "R11 configured cleared");
    rd_cfg(24'hE80000, 0, "R11 back in cfg window");
    acc(1, 0, 24'h250000, 4'h0, 0, 4'hF, 0, "R11 old base gone");
    // R8: commit with stale low nibble (reset value 0)
    acc(0, 1, 24'hE80048, 4'h4, 1, 4'hF, 1, "R8 stale commit");
    rd_cfg(24'h400000, 1, "R8 base 0x40");
    acc(1, 0, 24'h450000, 4'h0, 0, 4'hF, 1, "R8 not 0x45");
    // R10: shut-up
    do_reset();
    acc(0, 1, 24'hE8004C, 4'h0, 1, 4'hF, 0, "R10 silent write selected");
    acc(1, 0, 24'hE80000, 4'h0, 0, 4'hF, 0, "R10 cfg window quiet");
    acc(0, 1, 24'hE8004A, 4'h6, 0, 4'hF, 0, "R10 low write quiet");
    acc(0, 1, 24'hE80048, 4'h6, 0, 4'hF, 0, "R10 commit quiet");
    acc(1, 0, 24'h660000, 4'h0, 0, 4'hF, 0, "R10 no relocation");
    acc(0, 0, 24'h0, 4'h0, 0, 4'hF, 0, "R10 configured stays low");
    do_reset();
    rd_cfg(24'hE80002, 0, "R11 silent cleared");
    acc(0, 0, 24'h0, 4'h0, 0, 4'hF, 0, "R2 idle after read");
    @(negedge clk);
    rd = 0; wr = 0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule